// File: doc/BRIEF.md
# Power Management Capability Register Block

This block holds the two configuration dwords of the power management capability for a network controller. The first dword identifies the capability. It returns a fixed identifier and version, and a link to the next capability. That link is either a fixed pointer or zero, chosen by a strap bit. The second dword carries the wake control and status. It has a PME enable bit, a data-select index and a sticky PME status bit. Its top byte returns a state-dependent data byte picked by the index from a set of preloaded values.

The wake detectors sit outside the block and report three events: wake frame, magic packet and link change. Each event has its own detector enable. Any enabled event sets the status bit, whatever the PME enable holds. Software clears the bit by writing a one to it. While both status and enable are set, the active-low wake output is driven low. The block has two resets, power-on and warm. The status bit ignores the warm reset when wake from the unpowered state is supported.

Top module: `pm_cap_regs`

## Requirements
- R1: A read of dword 0 (cfg_addr_i=0) returns 8'h01 in bits 7:0, 3'b010 in bits 18:16, and zero in bits 31:19.
- R2: Bits 15:8 of dword 0 read 8'hE4 when vpd_en_i is 1 and 8'h00 when it is 0.
- R3: In a cycle where any source has both its event and its enable high (bit 0 wake frame, bit 1 magic packet, bit 2 link change), PME status (dword 1 bit 15) is 1 after the next edge, whatever the PME enable is. An event whose enable is low does not set it.
- R4: A write to dword 1 with cfg_be_i[1]=1 and wdata bit 15 = 1 clears PME status. A write with bit 15 = 0, or with cfg_be_i[1]=0, leaves it unchanged.
- R5: If a set and a clear fall in the same cycle, PME status is 1 afterwards.
- R6: pme_no is 0 exactly when PME status and PME enable are both 1.
- R7: A write to dword 1 with cfg_be_i[1]=1 stores wdata bit 8 as PME enable and bits 11:9 as the data select. Both read back at those positions. Dword 1 bits 7:0, 14:12 and 23:16 read 0.
- R8: Dword 1 bits 31:24 return byte pm_data_i[8*sel+7:8*sel] when pm_data_en_i is 1, and 0 when it is 0.
- R9: cfg_rdata_o takes the addressed dword at the edge that samples a read request. It holds its value in every cycle with no read request.
- R10: Writes to dword 0 change nothing that can be read back.
- R11: Power-on reset clears PME status, PME enable, select and read data. A warm reset clears enable, select and read data. It also clears PME status when d3cold_pme_i is 0, and leaves status unchanged when d3cold_pme_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Warm reset, active low, asynchronous |
| por_ni | input | 1 | Power-on reset, active low, asynchronous |
| cfg_req_i | input | 1 | Configuration access request |
| cfg_we_i | input | 1 | 1 = write, 0 = read |
| cfg_addr_i | input | 1 | Dword select: 0 = identity dword, 1 = control/status dword |
| cfg_be_i | input | 4 | Byte enables for writes |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data, registered |
| vpd_en_i | input | 1 | Strap: a further capability follows |
| pm_data_en_i | input | 1 | Strap: data byte reporting enabled |
| d3cold_pme_i | input | 1 | Strap: wake from unpowered state supported |
| pm_data_i | input | 64 | Preloaded data bytes, byte k in bits 8k+7:8k |
| wake_frame_i | input | 1 | Wake frame event |
| magic_pkt_i | input | 1 | Magic packet event |
| link_chg_i | input | 1 | Link change event |
| wake_frame_en_i | input | 1 | Wake frame detector enable |
| magic_pkt_en_i | input | 1 | Magic packet detector enable |
| link_chg_en_i | input | 1 | Link change detector enable |
| pme_no | output | 1 | Wake request, active low |

## Verification
A wake event setting PME status can fall in the same cycle as a software write-one-to-clear of that bit. The random stimulus draws events and dword 1 writes independently, so the two meet often. Directed steps also force the meeting once with status already set and once with status clear. After each edge the bench compares status and pme_no with a model in which the set wins.

// File: rtl/pm_cap_pkg.sv
package pm_cap_pkg;
  localparam logic [7:0] CAP_ID     = 8'h01;
  localparam logic [2:0] CAP_VER    = 3'b010;
  localparam logic [7:0] NEXT_PTR   = 8'hE4;
  localparam int         NUM_SRC    = 3;
  localparam int         STS_BIT    = 15;
  localparam int         EN_BIT     = 8;
  localparam int         SEL_LO     = 9;
  localparam int         DATA_LO    = 24;
  localparam logic       DW_IDENT   = 1'b0;
  localparam logic       DW_CTRL    = 1'b1;
endpackage

// File: rtl/pm_ctrl_reg.sv
module pm_ctrl_reg #(
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [7:0]       byte_i,   // byte lane 1 of dword 1
  output logic             pme_en_o,
  output logic [SEL_W-1:0] sel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pme_en_o <= 1'b0;
      sel_o    <= '0;
    end else if (wr_i) begin
      pme_en_o <= byte_i[0];
      sel_o    <= byte_i[SEL_W:1];
    end
  end
endmodule

// File: rtl/pm_status.sv
module pm_status
  import pm_cap_pkg::*;
(
  input  logic               clk_i,
  input  logic               por_ni,
  input  logic               rst_ni,
  input  logic               d3cold_i,
  input  logic [NUM_SRC-1:0] ev_i,
  input  logic [NUM_SRC-1:0] ev_en_i,
  input  logic               clr_i,
  input  logic               pme_en_i,
  output logic               sts_o,
  output logic               pme_no
);
  logic set;
  logic sts_rst_n;

  assign set       = |(ev_i & ev_en_i);
  // warm reset reaches the status bit only without unpowered-state wake
  assign sts_rst_n = por_ni & (rst_ni | d3cold_i);

  always_ff @(posedge clk_i or negedge sts_rst_n) begin
    if (!sts_rst_n)  sts_o <= 1'b0;
    else if (set)    sts_o <= 1'b1;
    else if (clr_i)  sts_o <= 1'b0;
  end

  assign pme_no = ~(sts_o & pme_en_i);

  a_r3_set: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
    set |=> sts_o);
  a_r4_clear: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
    (clr_i && !set) |=> !sts_o);
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
    (!clr_i && sts_o) |=> sts_o);
  a_r5_set_wins: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
    (clr_i && set) |=> sts_o);
endmodule

// File: rtl/pm_read_mux.sv
module pm_read_mux
  import pm_cap_pkg::*;
#(
  parameter int NUM_DATA = 8,
  parameter int SEL_W    = $clog2(NUM_DATA)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  por_ni,
  input  logic                  rd_i,
  input  logic                  addr_i,
  input  logic                  vpd_en_i,
  input  logic                  data_en_i,
  input  logic [8*NUM_DATA-1:0] data_i,
  input  logic                  pme_en_i,
  input  logic [SEL_W-1:0]      sel_i,
  input  logic                  sts_i,
  output logic [31:0]           rdata_o
);
  logic [7:0]  bytes [NUM_DATA];
  logic [7:0]  data_byte;
  logic [31:0] dw0, dw1;
  logic        rst_n;

  assign rst_n = rst_ni & por_ni;

  for (genvar k = 0; k < NUM_DATA; k++) begin : g_byte
    assign bytes[k] = data_i[8*k +: 8];
  end

  always_comb begin
    data_byte = 8'h00;
    if (data_en_i && (32'(sel_i) < NUM_DATA)) data_byte = bytes[sel_i];
  end

  always_comb begin
    dw0 = '0;
    dw0[7:0]   = CAP_ID;
    dw0[15:8]  = vpd_en_i ? NEXT_PTR : 8'h00;
    dw0[18:16] = CAP_VER;
    dw1 = '0;
    dw1[EN_BIT]                 = pme_en_i;
    dw1[SEL_LO +: SEL_W]        = sel_i;
    dw1[STS_BIT]                = sts_i;
    dw1[DATA_LO +: 8]           = data_byte;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)     rdata_o <= '0;
    else if (rd_i)  rdata_o <= (addr_i == DW_CTRL) ? dw1 : dw0;
  end

  a_r1_ident: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rd_i && addr_i == DW_IDENT) |=>
      (rdata_o[7:0] == 8'h01 && rdata_o[18:16] == 3'b010 && rdata_o[31:19] == '0));
  a_r2_next: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rd_i && addr_i == DW_IDENT) |=>
      (rdata_o[15:8] == ($past(vpd_en_i) ? 8'hE4 : 8'h00)));
  a_r7_reserved: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rd_i && addr_i == DW_CTRL) |=> (rdata_o[23:16] == '0 && rdata_o[7:0] == '0));
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_n)
    !rd_i |=> $stable(rdata_o));
endmodule

// File: rtl/pm_cap_regs.sv
module pm_cap_regs
  import pm_cap_pkg::*;
#(
  parameter int NUM_DATA = 8,
  parameter int SEL_W    = $clog2(NUM_DATA)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  por_ni,
  input  logic                  cfg_req_i,
  input  logic                  cfg_we_i,
  input  logic                  cfg_addr_i,
  input  logic [3:0]            cfg_be_i,
  input  logic [31:0]           cfg_wdata_i,
  output logic [31:0]           cfg_rdata_o,
  input  logic                  vpd_en_i,
  input  logic                  pm_data_en_i,
  input  logic                  d3cold_pme_i,
  input  logic [8*NUM_DATA-1:0] pm_data_i,
  input  logic                  wake_frame_i,
  input  logic                  magic_pkt_i,
  input  logic                  link_chg_i,
  input  logic                  wake_frame_en_i,
  input  logic                  magic_pkt_en_i,
  input  logic                  link_chg_en_i,
  output logic                  pme_no
);
  logic             wr_ctrl, rd, clr, pme_en, sts;
  logic [SEL_W-1:0] sel;
  logic             rst_n;
  logic             unused_ok;

  assign rst_n   = rst_ni & por_ni;
  assign wr_ctrl = cfg_req_i & cfg_we_i & (cfg_addr_i == DW_CTRL) & cfg_be_i[1];
  assign rd      = cfg_req_i & ~cfg_we_i;
  assign clr     = wr_ctrl & cfg_wdata_i[STS_BIT];
  assign unused_ok = ^{cfg_wdata_i[31:16], cfg_wdata_i[7:0], cfg_be_i[3:2], cfg_be_i[0]};

  pm_ctrl_reg #(.SEL_W(SEL_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .wr_i     (wr_ctrl),
    .byte_i   (cfg_wdata_i[15:8]),
    .pme_en_o (pme_en),
    .sel_o    (sel)
  );

  pm_status u_sts (
    .clk_i    (clk_i),
    .por_ni   (por_ni),
    .rst_ni   (rst_ni),
    .d3cold_i (d3cold_pme_i),
    .ev_i     ({link_chg_i, magic_pkt_i, wake_frame_i}),
    .ev_en_i  ({link_chg_en_i, magic_pkt_en_i, wake_frame_en_i}),
    .clr_i    (clr),
    .pme_en_i (pme_en),
    .sts_o    (sts),
    .pme_no   (pme_no)
  );

  pm_read_mux #(.NUM_DATA(NUM_DATA), .SEL_W(SEL_W)) u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .por_ni    (por_ni),
    .rd_i      (rd),
    .addr_i    (cfg_addr_i),
    .vpd_en_i  (vpd_en_i),
    .data_en_i (pm_data_en_i),
    .data_i    (pm_data_i),
    .pme_en_i  (pme_en),
    .sel_i     (sel),
    .sts_i     (sts),
    .rdata_o   (cfg_rdata_o)
  );
endmodule

// File: tb/pm_cap_regs_tb.sv
module pm_cap_regs_tb;
  logic        clk = 0;
  logic        rst_n = 0, por_n = 0;
  logic        req = 0, we = 0, addr = 0;
  logic [3:0]  be = 0;
  logic [31:0] wd = 0;
  logic [31:0] rdata;
  logic        vpd = 0, pden = 0, d3 = 0;
  logic [63:0] pdata = 64'h8877_6655_4433_2211;
  logic [2:0]  ev = 0, even = 0;
  logic        pme_n;

  int checks = 0, errors = 0;
  logic        m_sts = 0, m_en = 0;
  logic [2:0]  m_sel = 0;
  logic [31:0] exp_rd;

  always #2 clk = ~clk;  // 250 MHz

  pm_cap_regs u_dut (
    .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n),
    .cfg_req_i(req), .cfg_we_i(we), .cfg_addr_i(addr), .cfg_be_i(be),
    .cfg_wdata_i(wd), .cfg_rdata_o(rdata),
    .vpd_en_i(vpd), .pm_data_en_i(pden), .d3cold_pme_i(d3), .pm_data_i(pdata),
    .wake_frame_i(ev[0]), .magic_pkt_i(ev[1]), .link_chg_i(ev[2]),
    .wake_frame_en_i(even[0]), .magic_pkt_en_i(even[1]), .link_chg_en_i(even[2]),
    .pme_no(pme_n)
  );

  function automatic logic [31:0] exp_dw(input logic a);
    logic [7:0] db;
    db = pden ? pdata[8*m_sel +: 8] : 8'h00;
    if (a) return {db, 8'h00, m_sts, 3'b000, m_sel, m_en, 8'h00};
    return {13'b0, 3'b010, (vpd ? 8'hE4 : 8'h00), 8'h01};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // One cycle of stimulus, driven at a negedge; returns at the next negedge.
  task automatic op(input logic r, input logic w, input logic a, input logic [3:0] b,
                    input logic [31:0] d, input logic [2:0] e, input logic [2:0] en);
    logic set, clr;
    req = r; we = w; addr = a; be = b; wd = d; ev = e; even = en;
    if (r && !w) exp_rd = exp_dw(a);
    set = |(e & en);
    clr = r & w & a & b[1] & d[15];
    if (set) m_sts = 1; else if (clr) m_sts = 0;
    if (r && w && a && b[1]) begin m_en = d[8]; m_sel = d[11:9]; end
    @(negedge clk);
    req = 0; we = 0; ev = 0;
    check("R6 pme_no", {31'b0, pme_n}, {31'b0, ~(m_sts & m_en)});
  endtask

  task automatic rd_chk(input logic a, input string tag);
    op(1, 0, a, 4'h0, 32'h0, 3'b0, 3'b0);
    check(tag, rdata, exp_rd);
  endtask

  task automatic warm_reset();
    @(negedge clk) rst_n = 0;
    @(negedge clk) rst_n = 1;
    m_en = 0; m_sel = 0;
    if (!d3) m_sts = 0;
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    por_n = 1; rst_n = 1;
    @(negedge clk);
    check("R11 reset rdata", rdata, 32'h0);
    check("R11 reset pme_no", {31'b0, pme_n}, 32'h1);
    rd_chk(1, "R11 reset dword1");

    // identity dword and pointer strap
    vpd = 1; rd_chk(0, "R1 R2 dword0 vpd=1");
    vpd = 0; rd_chk(0, "R1 R2 dword0 vpd=0");
    op(1, 1, 0, 4'hF, 32'hFFFF_FFFF, 3'b0, 3'b0);
    rd_chk(0, "R10 dword0 write ignored");
    rd_chk(1, "R10 dword1 untouched");

    // control fields and data byte
    pden = 1;
    op(1, 1, 1, 4'h2, 32'hFFFF_0B00, 3'b0, 3'b0);  // en=1 sel=5
    rd_chk(1, "R7 R8 ctrl and data byte");
    pden = 0; rd_chk(1, "R8 data disabled");
    pden = 1;
    op(1, 1, 1, 4'hD, 32'h0000_0000, 3'b0, 3'b0);  // be[1]=0
    rd_chk(1, "R7 be1 low ignored");

    // set by each source, disabled source does not set
    op(0, 0, 0, 0, 0, 3'b001, 3'b110);
    rd_chk(1, "R3 disabled source no set");
    op(0, 0, 0, 0, 0, 3'b100, 3'b100);
    rd_chk(1, "R3 link change sets");
    op(1, 1, 1, 4'h2, 32'h0000_0100, 3'b0, 3'b0);  // write 0 to status
    rd_chk(1, "R4 write zero keeps");
    op(1, 1, 1, 4'h2, 32'h0000_8100, 3'b0, 3'b0);
    rd_chk(1, "R4 write one clears");
    op(1, 1, 1, 4'h2, 32'h0000_0000, 3'b010, 3'b010); // en=0, magic sets
    rd_chk(1, "R3 set with enable off");

    // collision: set wins, with status high and with status low
    op(1, 1, 1, 4'h2, 32'h0000_8100, 3'b001, 3'b001);
    rd_chk(1, "R5 collision status high");
    op(1, 1, 1, 4'h2, 32'h0000_8100, 3'b0, 3'b0);
    op(1, 1, 1, 4'h2, 32'h0000_8100, 3'b010, 3'b011);
    rd_chk(1, "R5 collision status low");

    // read data holds with no request
    rd_chk(0, "R9 read dword0");
    vpd = ~vpd; pden = ~pden;
    op(0, 0, 0, 0, 0, 3'b0, 3'b0);
    op(1, 1, 1, 4'h2, 32'h0000_0300, 3'b0, 3'b0);
    check("R9 rdata held", rdata, exp_rd);

    // warm and power-on reset behaviour for status
    op(0, 0, 0, 0, 0, 3'b001, 3'b001);
    d3 = 0; warm_reset();
    rd_chk(1, "R11 warm reset clears without d3cold");
    op(0, 0, 0, 0, 0, 3'b001, 3'b001);
    d3 = 1; warm_reset();
    rd_chk(1, "R11 warm reset keeps with d3cold");
    @(negedge clk) por_n = 0;
    @(negedge clk) por_n = 1;
    m_sts = 0; m_en = 0; m_sel = 0;
    rd_chk(1, "R11 power-on clears status");

    // constrained random mix
    for (int i = 0; i < 2000; i++) begin
      logic [2:0] e, en;
      logic [3:0] b;
      int k;
      e  = 3'($urandom & $urandom);
      en = 3'($urandom);
      b  = 4'($urandom);
      k  = $urandom % 4;
      vpd  = 1'($urandom);
      pden = 1'($urandom);
      if (i % 97 == 0) pdata = {$urandom, $urandom};
      case (k)
        0: op(0, 0, 0, 0, 0, e, en);
        1: begin
             op(1, 0, 1'($urandom), 4'h0, 32'h0, e, en);
             check("R7 R8 R1 R2 random read", rdata, exp_rd);
           end
        2: op(1, 1, 1, b, $urandom, e, en);
        default: op(1, 1, 0, b, $urandom, e, en);
      endcase
      if (i % 500 == 499) begin d3 = 1'($urandom); warm_reset(); end
    end
    rd_chk(1, "R3 R4 R5 final state");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule